// File: doc/BRIEF.md
# Scan Vector Sequencer

This controller drives a circuit whose flip-flops have been stitched into a single scan chain, and applies a fixed list of combinational test vectors to it. It runs once for each accepted start pulse. Each vector has two parts: a present-state word that is shifted serially into the chain with the test-control line low, and a primary-input word that is presented for exactly one capture clock with the test-control line high.

Loading vector k+1 and unloading the captured response of vector k happen in the same shift cycles. After the last capture, one extra shift phase with a zero serial input drains the final response. The primary outputs are compared at each capture edge and the serial output is compared bit by bit during the shift phase that follows. Any difference sets a sticky mismatch flag. A done flag marks the end of the run.

The vector list and the expected responses are built at elaboration from a fixed generator and a fixed golden function, so the list lives inside the block as constant logic.

Top module: `scan_seq_top`

## Requirements
- R1: While idle (after reset or after a run), tc is 1, scan_si is 0, pi_o is 0 and busy is 0. After reset, done and mismatch are also 0.
- R2: Vector k (0-based) takes W = low 32 bits of (k+1)*0x9E3779B1. Its state is W[NSFF-1:0] and its input word is W[13 +: NPI]. The state is shifted in most-significant bit first, so a chain that moves one place toward its top on every shift holds exactly that state when the capture cycle comes.
- R3: Each capture is a single cycle with tc=1 in which pi_o carries the input word of the current vector. There are exactly NVEC captures per run, in vector order.
- R4: Exactly NSFF consecutive shift cycles with tc=0 come before every capture, and a shift cycle always follows a capture.
- R5: busy stays high for (NVEC+1)*NSFF+NVEC cycles, starting with the cycle after start is sampled in idle. A start pulse while busy has no effect on the sequence or on its length.
- R6: After the last capture there is a drain phase of exactly NSFF shift cycles, and scan_si is 0 throughout it.
- R7: pi_o is 0 in every shift cycle.
- R8: done rises in the cycle in which busy falls. It stays high until the next accepted start, which clears it.
- R9: po_i is compared with the expected output word at the end of each capture cycle. A difference makes mismatch read 1 from the next cycle.
- R10: In shift cycle j (0-based) after the capture of vector k, scan_so_i is compared with bit NSFF-1-j of the expected next state of vector k. A difference makes mismatch read 1 from the next cycle. This includes the drain phase.
- R11: mismatch is sticky until the next accepted start, which clears it.
- R12: The expected next state is the state rotated left by one within NSFF bits, XOR the input word zero-extended. Expected output bit i is the XOR of the state bits j with j mod NPO = i, XOR input bit (i mod NPI). A circuit that matches this leaves mismatch at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when sampled high in idle |
| tc | output | 1 | Test control: 0 while shifting, 1 for capture and while idle |
| scan_si | output | 1 | Serial data into the chain |
| pi_o | output | NPI | Primary-input word for the circuit under test |
| po_i | input | NPO | Primary outputs of the circuit under test |
| scan_so_i | input | 1 | Serial data out of the chain |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | Run finished; held until the next start |
| mismatch | output | 1 | Sticky compare-failure flag |

## Verification
tc, pi_o and scan_si follow the controller state in the same cycle. The bench therefore reads them, and the chain contents of its own circuit model, at the falling edge inside each cycle. A compare result appears one cycle after the cycle it judges: the bench checks mismatch at 0 in the faulty capture or faulty drain cycle itself and at 1 in the cycle after. Run length and done are checked in the first cycle with busy low, and the clearing of both flags in the cycle after start is accepted.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;

    localparam int          WORD_W    = 32;
    localparam logic [31:0] GEN_MULT  = 32'h9E3779B1;
    localparam int          PI_OFFSET = 13;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LOAD  = 2'd1,
        SQ_CAPT  = 2'd2,
        SQ_DRAIN = 2'd3
    } seq_state_e;

    function automatic logic [WORD_W-1:0] low_mask(input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++)
            if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] gen_word(input int k);
        return 32'(k + 1) * GEN_MULT;
    endfunction

    function automatic logic [WORD_W-1:0] vec_state(input int k, input int nsff);
        return gen_word(k) & low_mask(nsff);
    endfunction

    function automatic logic [WORD_W-1:0] vec_input(input int k, input int npi);
        return (gen_word(k) >> PI_OFFSET) & low_mask(npi);
    endfunction

    // golden next state: rotate left by one inside nsff bits, then fold in inputs
    function automatic logic [WORD_W-1:0] gold_next(input logic [WORD_W-1:0] st,
                                                    input logic [WORD_W-1:0] pv,
                                                    input int nsff, input int npi);
        logic [WORD_W-1:0] r;
        r = ((st << 1) | (st >> (nsff - 1))) & low_mask(nsff);
        return r ^ (pv & low_mask(npi));
    endfunction

    // golden outputs: state bits folded modulo npo, xor one input bit each
    function automatic logic [WORD_W-1:0] gold_out(input logic [WORD_W-1:0] st,
                                                   input logic [WORD_W-1:0] pv,
                                                   input int nsff, input int npi,
                                                   input int npo);
        logic [WORD_W-1:0] r;
        logic [WORD_W-1:0] t;
        logic              b;
        r = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < npo) begin
                t = pv >> (i % npi);
                b = t[0];
                for (int j = 0; j < WORD_W; j++)
                    if (j < nsff && (j % npo) == i) b = b ^ st[j];
                r[i] = b;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/scan_seq_rom.sv
`timescale 1ns/1ps
module scan_seq_rom
    import scan_seq_pkg::*;
#(
    parameter int NSFF = 8,
    parameter int NPI  = 4,
    parameter int NPO  = 4,
    parameter int NVEC = 6,
    parameter int VW   = $clog2(NVEC + 1)
) (
    input  logic [VW-1:0]   cur_idx,
    input  logic [VW-1:0]   nxt_idx,
    output logic [NSFF-1:0] cur_st,
    output logic [NPI-1:0]  cur_pi,
    output logic [NPO-1:0]  cur_epo,
    output logic [NSFF-1:0] cur_enx,
    output logic [NSFF-1:0] nxt_st
);

    logic [NSFF-1:0] st_tab  [NVEC];
    logic [NPI-1:0]  pi_tab  [NVEC];
    logic [NPO-1:0]  epo_tab [NVEC];
    logic [NSFF-1:0] enx_tab [NVEC];

    for (genvar g = 0; g < NVEC; g++) begin : g_ent
        localparam logic [WORD_W-1:0] ST  = vec_state(g, NSFF);
        localparam logic [WORD_W-1:0] PV  = vec_input(g, NPI);
        localparam logic [WORD_W-1:0] NX  = gold_next(ST, PV, NSFF, NPI);
        localparam logic [WORD_W-1:0] OUT = gold_out(ST, PV, NSFF, NPI, NPO);
        assign st_tab[g]  = ST[NSFF-1:0];
        assign pi_tab[g]  = PV[NPI-1:0];
        assign epo_tab[g] = OUT[NPO-1:0];
        assign enx_tab[g] = NX[NSFF-1:0];
    end

    // out-of-range index reads as all zero (feeds zeros into the drain phase)
    always_comb begin
        cur_st  = '0;
        cur_pi  = '0;
        cur_epo = '0;
        cur_enx = '0;
        nxt_st  = '0;
        for (int i = 0; i < NVEC; i++) begin
            if (cur_idx == VW'(i)) begin
                cur_st  = st_tab[i];
                cur_pi  = pi_tab[i];
                cur_epo = epo_tab[i];
                cur_enx = enx_tab[i];
            end
            if (nxt_idx == VW'(i)) nxt_st = st_tab[i];
        end
    end

endmodule

// File: rtl/scan_seq_ctrl.sv
`timescale 1ns/1ps
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int NSFF = 8,
    parameter int NVEC = 6,
    parameter int BW   = (NSFF > 1) ? $clog2(NSFF) : 1,
    parameter int VW   = $clog2(NVEC + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_state_e st,
    output logic [VW-1:0] veccnt,
    output logic       start_ok,
    output logic       done
);

    logic [BW-1:0] bitcnt;
    logic          last_bit;

    assign last_bit = (bitcnt == BW'(NSFF - 1));
    assign start_ok = (st == SQ_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            bitcnt <= '0;
            veccnt <= '0;
            done   <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st     <= SQ_LOAD;
                        bitcnt <= '0;
                        veccnt <= '0;
                        done   <= 1'b0;
                    end
                end
                SQ_LOAD: begin
                    if (last_bit) begin
                        bitcnt <= '0;
                        st     <= SQ_CAPT;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                SQ_CAPT: begin
                    veccnt <= veccnt + 1'b1;
                    st     <= (veccnt == VW'(NVEC - 1)) ? SQ_DRAIN : SQ_LOAD;
                end
                SQ_DRAIN: begin
                    if (last_bit) begin
                        bitcnt <= '0;
                        veccnt <= '0;
                        done   <= 1'b1;
                        st     <= SQ_IDLE;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/scan_seq_dp.sv
`timescale 1ns/1ps
module scan_seq_dp #(
    parameter int NSFF = 8,
    parameter int NPI  = 4,
    parameter int NPO  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_ok,
    input  logic            capt,
    input  logic            shifting,
    input  logic            so_check,
    input  logic [NSFF-1:0] cur_st,
    input  logic [NPI-1:0]  cur_pi,
    input  logic [NPO-1:0]  cur_epo,
    input  logic [NSFF-1:0] cur_enx,
    input  logic [NSFF-1:0] nxt_st,
    input  logic [NPO-1:0]  po_i,
    input  logic            so_i,
    output logic            si,
    output logic [NPI-1:0]  pi_o,
    output logic            mismatch
);

    logic [NSFF-1:0] load_sr;   // bits still to be shifted in, MSB leaves first
    logic [NSFF-1:0] exp_sr;    // expected response still to come out
    logic            po_bad;
    logic            so_bad;

    assign si     = shifting & load_sr[NSFF-1];
    assign pi_o   = capt ? cur_pi : '0;
    assign po_bad = capt && (po_i != cur_epo);
    assign so_bad = so_check && (so_i != exp_sr[NSFF-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_sr <= '0;
            exp_sr  <= '0;
        end else if (start_ok) begin
            load_sr <= cur_st;
        end else if (capt) begin
            load_sr <= nxt_st;
            exp_sr  <= cur_enx;
        end else if (shifting) begin
            load_sr <= {load_sr[NSFF-2:0], 1'b0};
            exp_sr  <= {exp_sr[NSFF-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  mismatch <= 1'b0;
        else if (start_ok)        mismatch <= 1'b0;
        else if (po_bad | so_bad) mismatch <= 1'b1;
    end

endmodule

// File: rtl/scan_seq_top.sv
`timescale 1ns/1ps
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int NSFF = 8,
    parameter int NPI  = 4,
    parameter int NPO  = 4,
    parameter int NVEC = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    output logic           tc,
    output logic           scan_si,
    output logic [NPI-1:0] pi_o,
    input  logic [NPO-1:0] po_i,
    input  logic           scan_so_i,
    output logic           busy,
    output logic           done,
    output logic           mismatch
);

    localparam int VW = $clog2(NVEC + 1);

    seq_state_e      st;
    logic [VW-1:0]   veccnt;
    logic [VW-1:0]   nxt_idx;
    logic            start_ok;
    logic            capt;
    logic            shifting;
    logic            so_check;
    logic [NSFF-1:0] cur_st;
    logic [NPI-1:0]  cur_pi;
    logic [NPO-1:0]  cur_epo;
    logic [NSFF-1:0] cur_enx;
    logic [NSFF-1:0] nxt_st;

    scan_seq_ctrl #(.NSFF(NSFF), .NVEC(NVEC)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .st(st), .veccnt(veccnt), .start_ok(start_ok), .done(done)
    );

    assign nxt_idx  = veccnt + 1'b1;
    assign capt     = (st == SQ_CAPT);
    assign shifting = (st == SQ_LOAD) || (st == SQ_DRAIN);
    assign so_check = shifting && (veccnt != '0);
    assign busy     = (st != SQ_IDLE);
    assign tc       = !shifting;

    scan_seq_rom #(.NSFF(NSFF), .NPI(NPI), .NPO(NPO), .NVEC(NVEC), .VW(VW)) u_rom (
        .cur_idx(veccnt), .nxt_idx(nxt_idx),
        .cur_st(cur_st), .cur_pi(cur_pi), .cur_epo(cur_epo),
        .cur_enx(cur_enx), .nxt_st(nxt_st)
    );

    scan_seq_dp #(.NSFF(NSFF), .NPI(NPI), .NPO(NPO)) u_dp (
        .clk(clk), .rst(rst), .start_ok(start_ok), .capt(capt),
        .shifting(shifting), .so_check(so_check),
        .cur_st(cur_st), .cur_pi(cur_pi), .cur_epo(cur_epo),
        .cur_enx(cur_enx), .nxt_st(nxt_st),
        .po_i(po_i), .so_i(scan_so_i),
        .si(scan_si), .pi_o(pi_o), .mismatch(mismatch)
    );

endmodule

// File: rtl/scan_seq_chk.sv
`timescale 1ns/1ps
module scan_seq_chk #(
    parameter int NSFF = 8,
    parameter int NPI  = 4,
    parameter int NVEC = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           tc,
    input logic           scan_si,
    input logic [NPI-1:0] pi_o,
    input logic           busy,
    input logic           done,
    input logic           mismatch
);

    localparam int TOTAL = (NVEC + 1) * NSFF + NVEC;

    logic [31:0] run_cnt;
    logic [31:0] busy_cnt;
    logic        accept;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            busy_cnt <= '0;
        end else begin
            run_cnt  <= (busy && !tc) ? run_cnt + 1 : '0;
            busy_cnt <= busy ? busy_cnt + 1 : '0;
        end
    end

    p_idle_outputs_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tc && !scan_si && pi_o == '0));

    p_shift_run_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && tc) |-> (run_cnt == 32'(NSFF)));

    p_capture_then_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && tc) |=> (busy && !tc));

    p_run_length_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_cnt == 32'(TOTAL)));

    p_pi_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !tc) |-> (pi_o == '0));

    p_done_rise_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !accept) |=> done);

    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (mismatch && !accept) |=> mismatch);

    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!mismatch && !done && busy));

endmodule

bind scan_seq_top scan_seq_chk #(.NSFF(NSFF), .NPI(NPI), .NVEC(NVEC)) i_chk (
    .clk(clk), .rst(rst), .start(start), .tc(tc), .scan_si(scan_si),
    .pi_o(pi_o), .busy(busy), .done(done), .mismatch(mismatch)
);

// File: tb/test_scan_seq_top.sv
`timescale 1ns/1ps
module test_scan_seq_top;

    localparam int NSFF      = 8;
    localparam int NPI       = 4;
    localparam int NPO       = 4;
    localparam int NVEC      = 6;
    localparam int TOTAL     = (NVEC + 1) * NSFF + NVEC;
    localparam int FLIP_POS  = 2;
    localparam int PO_FAULT  = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           tc, scan_si, scan_so_i, busy, done, mismatch;
    logic [NPI-1:0] pi_o;
    logic [NPO-1:0] po_i;

    always #2.5 clk = ~clk;

    scan_seq_top #(.NSFF(NSFF), .NPI(NPI), .NPO(NPO), .NVEC(NVEC)) i_scan_seq_top (
        .clk(clk), .rst(rst), .start(start), .tc(tc), .scan_si(scan_si),
        .pi_o(pi_o), .po_i(po_i), .scan_so_i(scan_so_i),
        .busy(busy), .done(done), .mismatch(mismatch)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- stimulus model (R2) and circuit model (R12) ----------------
    function automatic logic [NSFF-1:0] tb_state(input int k);
        logic [31:0] w;
        w = 32'(k + 1) * 32'h9E3779B1;
        return w[NSFF-1:0];
    endfunction

    function automatic logic [NPI-1:0] tb_input(input int k);
        logic [31:0] w;
        w = 32'(k + 1) * 32'h9E3779B1;
        return w[13 +: NPI];
    endfunction

    function automatic logic [NSFF-1:0] tb_next(input logic [NSFF-1:0] s, input logic [NPI-1:0] p);
        logic [NSFF-1:0] r;
        r = {s[NSFF-2:0], s[NSFF-1]};
        return r ^ NSFF'(p);
    endfunction

    function automatic logic [NPO-1:0] tb_out(input logic [NSFF-1:0] s, input logic [NPI-1:0] p);
        logic [NPO-1:0] r;
        for (int i = 0; i < NPO; i++) begin
            logic b;
            b = p[i % NPI];
            for (int j = i; j < NSFF; j += NPO) b = b ^ s[j];
            r[i] = b;
        end
        return r;
    endfunction

    int              fault_mode = 0;   // 0 none, 1 output fault, 2 state fault
    logic [NSFF-1:0] chain;
    int              cap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain   <= '0;
            cap_cnt <= 0;
        end else begin
            if (start && !busy) cap_cnt <= 0;
            else if (busy && tc) cap_cnt <= cap_cnt + 1;
            if (busy && !tc)
                chain <= {chain[NSFF-2:0], scan_si};
            else if (busy && tc)
                chain <= tb_next(chain, pi_o) ^
                         ((fault_mode == 2 && cap_cnt == NVEC - 1) ? NSFF'(1 << FLIP_POS) : '0);
        end
    end

    assign scan_so_i = chain[NSFF-1];
    assign po_i = tb_out(chain, pi_o) ^
                  ((fault_mode == 1 && busy && tc && cap_cnt == PO_FAULT) ? NPO'(1) : '0);

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [NSFF-1:0] st;
        logic [NPI-1:0]  pv;
    } sb_item_t;

    sb_item_t sb_q[$];

    int cyc, run_len, caps, drain_idx, runs_done;
    bit active, pi_bad, si_bad, po_watch;

    initial begin
        runs_done = 0;
        active    = 0;
    end

    always @(negedge clk) begin
        if (busy) begin
            if (!active) begin
                active = 1; cyc = 0; run_len = 0; caps = 0; drain_idx = 0;
                pi_bad = 0; si_bad = 0; po_watch = 0;
            end
            cyc++;
            if (po_watch) begin
                check(mismatch === 1'b1, "R9 output fault flagged next cycle", int'(mismatch), 1);
                po_watch = 0;
            end
            if (tc) begin
                if (sb_q.size() == 0) begin
                    check(0, "R3 unexpected capture", caps, NVEC);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check(chain == it.st, "R2 loaded state", int'(chain), int'(it.st));
                    check(pi_o == it.pv, "R3 capture inputs", int'(pi_o), int'(it.pv));
                end
                check(run_len == NSFF, "R4 shifts before capture", run_len, NSFF);
                if (fault_mode == 1 && caps == PO_FAULT) begin
                    check(mismatch === 1'b0, "R9 flag not early", int'(mismatch), 0);
                    po_watch = 1;
                end
                caps++;
                run_len = 0;
            end else begin
                run_len++;
                if (pi_o != '0) pi_bad = 1;
                if (caps == NVEC) begin
                    if (scan_si) si_bad = 1;
                    if (fault_mode == 2 && drain_idx == NSFF - 1 - FLIP_POS)
                        check(mismatch === 1'b0, "R10 flag not early", int'(mismatch), 0);
                    if (fault_mode == 2 && drain_idx == NSFF - FLIP_POS)
                        check(mismatch === 1'b1, "R10 serial fault flagged", int'(mismatch), 1);
                    drain_idx++;
                end
            end
        end else if (active) begin
            active = 0;
            check(cyc == TOTAL, "R5 busy length", cyc, TOTAL);
            check(done === 1'b1, "R8 done with busy fall", int'(done), 1);
            check(!pi_bad, "R7 inputs zero while shifting", int'(pi_bad), 0);
            check(!si_bad, "R6 drain serial zero", int'(si_bad), 0);
            check(drain_idx == NSFF, "R6 drain length", drain_idx, NSFF);
            check(caps == NVEC, "R3 capture count", caps, NVEC);
            if (fault_mode == 0)
                check(mismatch === 1'b0, "R12 good circuit passes", int'(mismatch), 0);
            else
                check(mismatch === 1'b1, "R11 flag sticky to end", int'(mismatch), 1);
            runs_done++;
        end
    end

    // ---------------- driver ----------------
    task automatic run_seq(input int mode, input bit spurious);
        int r0;
        fault_mode = mode;
        for (int k = 0; k < NVEC; k++) sb_q.push_back('{st: tb_state(k), pv: tb_input(k)});
        r0 = runs_done;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy && !done && !mismatch, "R11 start clears flags",
              int'({busy, done, mismatch}), 4);
        if (spurious) begin
            repeat (20) @(negedge clk);
            start = 1'b1;   // R5: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (runs_done == r0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(done && !busy, "R8 done held in idle", int'({done, busy}), 2);
        check(tc && !scan_si && pi_o == '0, "R1 idle outputs after run",
              int'({tc, scan_si}), 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tc && !scan_si && pi_o == '0 && !busy && !done && !mismatch,
              "R1 reset state", int'({tc, scan_si, busy, done, mismatch}), 16);
        run_seq(0, 1'b1);
        run_seq(1, 1'b0);
        run_seq(2, 1'b0);
        run_seq(0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule